// File: doc/BRIEF.md
# Thermal Throttle Clock-Stop Controller

This block cuts core power when the die runs hot. It watches a digital over-temperature flag. While the flag is high, it keeps sending a stop-clock request to the core clock gating logic. Each request goes through the following steps in a loop:

1. Raise the request.
2. Wait for the core to acknowledge that its clock has stopped.
3. Hold the stop for a programmed number of cycles.
4. Drop the request and wait for the acknowledge to fall.
5. Let the core run for a programmed number of cycles.

The fraction of time spent stopped sets the fraction of power saved, at an unchanged clock frequency.

The request reuses the existing low-power stop path as a high-priority internal source. The controller raises it one cycle after it sees the hot flag. A watchdog bounds both handshake phases by a programmed overhead limit, so the time the core spends not executing stays small and known. All three lengths are taken from configuration inputs only while the controller is idle. A status counter reports how many throttle cycles have completed.

Top module: `thermal_throttle_ctl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `stop_req_o`, `err_o` and `cycles_o` are all zero.
- R2: When the controller is idle and samples `hot_i` high at a clock edge, `stop_req_o` is high right after that same edge.
- R3: From the first edge at which `stop_ack_i` is sampled high while the request waits, `stop_req_o` stays high for exactly N cycles, where N is the captured stop length. A stop length of 0 behaves as 1.
- R4: The run interval starts at the edge where `stop_ack_i` is sampled low after the request was dropped. It lasts M cycles, where M is the captured run length and 0 behaves as 1. After it, `stop_req_o` rises again if `hot_i` is still high.
- R5: If `hot_i` falls while the clock is stopped, the stop window still runs its full N cycles. The cycle is then counted, and no new request follows.
- R6: If `hot_i` is sampled low during the run interval, the controller goes idle at that edge, and no further request is made.
- R7: If `stop_ack_i` stays low for L cycles after the request rises, `err_o` pulses high for one cycle, `stop_req_o` drops and the controller goes idle. L is the captured overhead limit, and 0 behaves as 1.
- R8: If `stop_ack_i` stays high for L cycles after the request is dropped, `err_o` pulses high for one cycle, the controller goes idle, and `cycles_o` does not advance.
- R9: `cycles_o` advances by one, wrapping at its width, in the cycle after `stop_ack_i` is seen low following a stop window.
- R10: The stop, run and overhead lengths are captured only while the controller is idle. Changing them during throttling has no effect until the next idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hot_i | input | 1 | Over-temperature flag, already synchronous to `clk` |
| stop_ack_i | input | 1 | Core acknowledge: clock is stopped |
| cfg_stop_len_i | input | LEN_W | Stop window length in cycles |
| cfg_run_len_i | input | LEN_W | Run interval length in cycles |
| cfg_ovh_lim_i | input | LEN_W | Handshake overhead limit in cycles |
| stop_req_o | output | 1 | Stop-clock request to the core |
| err_o | output | 1 | One-cycle pulse on a handshake timeout |
| cycles_o | output | CNT_W | Count of completed throttle cycles |

## Verification
Each output is due a fixed number of edges after the stimulus that causes it:

- The request rises one edge after the hot flag is seen.
- It holds for N edges once the acknowledge is seen.
- It stays low for M+1 sampled cycles when the acknowledge follows it with a one-cycle lag.
- A timeout pulse appears at the L-th edge without an answer, or at the (L+1)-th sample counted from the flag when waiting for the first acknowledge.
- The cycle count moves at the edge where the acknowledge is seen low.

The bench samples 1 ns after each rising edge, and its acknowledge responder drives 2 ns after the edge. Every measured length therefore comes from a whole number of edges and is compared against these formulas.

// File: rtl/thermal_throttle_pkg.sv
package thermal_throttle_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_REQ     = 3'd1,
    ST_STOPPED = 3'd2,
    ST_RESUME  = 3'd3,
    ST_RUN     = 3'd4
  } tt_state_e;

endpackage

// File: rtl/tt_cfg_shadow.sv
module tt_cfg_shadow #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [LEN_W-1:0] stop_len,
  input  logic [LEN_W-1:0] run_len,
  input  logic [LEN_W-1:0] ovh_lim,
  output logic [LEN_W-1:0] stop_m1,
  output logic [LEN_W-1:0] run_m1,
  output logic [LEN_W-1:0] ovh_m1
);

  // zero means one cycle; result is length minus one, used as a terminal count
  function automatic logic [LEN_W-1:0] len_minus_one(input logic [LEN_W-1:0] len);
    if (len == '0) return '0;
    return len - LEN_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_m1 <= '0;
      run_m1  <= '0;
      ovh_m1  <= '0;
    end else if (capture) begin
      stop_m1 <= len_minus_one(stop_len);
      run_m1  <= len_minus_one(run_len);
      ovh_m1  <= len_minus_one(ovh_lim);
    end
  end

endmodule

// File: rtl/tt_down_timer.sv
module tt_down_timer #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_val,
  output logic             zero
);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - LEN_W'(1);
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/tt_overhead_watchdog.sv
module tt_overhead_watchdog #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [LEN_W-1:0] lim_m1,
  output logic             expire
);

  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en && cnt_q != lim_m1) cnt_q <= cnt_q + LEN_W'(1);
  end

  assign expire = en && (cnt_q == lim_m1);

endmodule

// File: rtl/tt_event_counter.sv
module tt_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  function automatic logic [CNT_W-1:0] wrap_inc(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (inc) count <= wrap_inc(count);
  end

endmodule

// File: rtl/thermal_throttle_ctl.sv
module thermal_throttle_ctl
  import thermal_throttle_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hot_i,
  input  logic             stop_ack_i,
  input  logic [LEN_W-1:0] cfg_stop_len_i,
  input  logic [LEN_W-1:0] cfg_run_len_i,
  input  logic [LEN_W-1:0] cfg_ovh_lim_i,
  output logic             stop_req_o,
  output logic             err_o,
  output logic [CNT_W-1:0] cycles_o
);

  tt_state_e        state_q, state_d;
  logic [LEN_W-1:0] stop_m1, run_m1, ovh_m1;
  logic             tmr_zero, tmr_load;
  logic [LEN_W-1:0] tmr_val;
  logic             wd_en, wd_clr, wd_expire;
  logic             err_q;

  // named internal events
  logic in_idle, start_req, got_ack, win_done, ack_gone, run_done, run_abort, wd_trip;

  assign in_idle   = (state_q == ST_IDLE);
  assign start_req = in_idle && hot_i;
  assign got_ack   = (state_q == ST_REQ) && stop_ack_i;
  assign win_done  = (state_q == ST_STOPPED) && tmr_zero;
  assign ack_gone  = (state_q == ST_RESUME) && !stop_ack_i;
  assign run_abort = (state_q == ST_RUN) && !hot_i;
  assign run_done  = (state_q == ST_RUN) && hot_i && tmr_zero;
  assign wd_en     = ((state_q == ST_REQ) && !stop_ack_i) ||
                     ((state_q == ST_RESUME) && stop_ack_i);
  assign wd_trip   = wd_en && wd_expire;

  tt_cfg_shadow #(.LEN_W(LEN_W)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .capture  (in_idle),
    .stop_len (cfg_stop_len_i),
    .run_len  (cfg_run_len_i),
    .ovh_lim  (cfg_ovh_lim_i),
    .stop_m1  (stop_m1),
    .run_m1   (run_m1),
    .ovh_m1   (ovh_m1)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (hot_i) state_d = ST_REQ;
      ST_REQ:     if (stop_ack_i) state_d = ST_STOPPED;
                  else if (wd_expire) state_d = ST_IDLE;
      ST_STOPPED: if (tmr_zero) state_d = ST_RESUME;
      ST_RESUME:  if (!stop_ack_i) state_d = ST_RUN;
                  else if (wd_expire) state_d = ST_IDLE;
      ST_RUN:     if (!hot_i) state_d = ST_IDLE;
                  else if (tmr_zero) state_d = ST_REQ;
      default:    state_d = ST_IDLE;
    endcase
  end

  assign tmr_load = got_ack || ack_gone;
  assign tmr_val  = got_ack ? stop_m1 : run_m1;
  assign wd_clr   = (state_d != state_q) || !wd_en;

  tt_down_timer #(.LEN_W(LEN_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  tt_overhead_watchdog #(.LEN_W(LEN_W)) u_wd (
    .clk    (clk),
    .rst    (rst),
    .clr    (wd_clr),
    .en     (wd_en),
    .lim_m1 (ovh_m1),
    .expire (wd_expire)
  );

  tt_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .inc   (ack_gone),
    .count (cycles_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= wd_trip;
    end
  end

  assign stop_req_o = (state_q == ST_REQ) || (state_q == ST_STOPPED);
  assign err_o      = err_q;

endmodule

// File: rtl/tt_checker.sv
module tt_checker
  import thermal_throttle_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             hot,
  input logic             ack,
  input logic             req,
  input logic             err,
  input logic [CNT_W-1:0] cycles,
  input tt_state_e        st,
  input logic             win_done,
  input logic             wd_trip
);

  assert_req_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && hot) |=> req);

  assert_window_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_STOPPED && !win_done) |=> req);

  assert_req_fall_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(req) |-> ($past(win_done) || $past(wd_trip)));

  assert_run_abort_R6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && !hot) |=> (st == ST_IDLE && !req));

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> (st == ST_IDLE));

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    (cycles != $past(cycles)) |-> ($past(st) == ST_RESUME && !$past(ack)));

endmodule

bind thermal_throttle_ctl tt_checker #(.CNT_W(CNT_W)) u_tt_checker (
  .clk      (clk),
  .rst      (rst),
  .hot      (hot_i),
  .ack      (stop_ack_i),
  .req      (stop_req_o),
  .err      (err_o),
  .cycles   (cycles_o),
  .st       (state_q),
  .win_done (win_done),
  .wd_trip  (wd_trip)
);

// File: tb/thermal_throttle_ctl_tb_top.sv
`timescale 1ns/1ps
module thermal_throttle_ctl_tb_top;
  localparam int LEN_W = 16;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hot = 1'b0;
  logic ack = 1'b0;
  logic auto_ack = 1'b0;
  logic [LEN_W-1:0] cfg_stop = 16'd3, cfg_run = 16'd5, cfg_ovh = 16'd8;
  logic req, err;
  logic [CNT_W-1:0] cycles;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  thermal_throttle_ctl #(.LEN_W(LEN_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .hot_i(hot), .stop_ack_i(ack),
    .cfg_stop_len_i(cfg_stop), .cfg_run_len_i(cfg_run), .cfg_ovh_lim_i(cfg_ovh),
    .stop_req_o(req), .err_o(err), .cycles_o(cycles)
  );

  // core model: acknowledge follows the request one cycle later
  initial forever begin
    @(posedge clk); #2;
    if (auto_ack) ack = req;
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic go_idle();
    hot = 1'b0; auto_ack = 1'b0; ack = 1'b0;
    for (int i = 0; i < 40; i++) step();
  endtask

  // count stopped samples (req and ack both high) until req falls
  task automatic measure_window(output int n);
    n = 0;
    for (int i = 0; i < 1000 && req; i++) begin
      step();
      if (req && ack) n++;
    end
  endtask

  // count low samples of req until it rises
  task automatic measure_gap(output int g);
    g = 1;
    for (int i = 0; i < 1000; i++) begin
      step();
      if (req) break;
      g++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    step(); step();
    chk(req == 1'b0, "R1 req in reset", int'(req), 0);
    chk(err == 1'b0, "R1 err in reset", int'(err), 0);
    rst = 1'b0;
    step();
    chk(cycles == '0, "R1 cycles after reset", int'(cycles), 0);
    chk(req == 1'b0, "R1 req after reset", int'(req), 0);
  endtask

  task automatic t_basic(input int n, input int m);
    int w, g;
    int en, em;
    logic [CNT_W-1:0] c0;
    en = (n == 0) ? 1 : n;
    em = (m == 0) ? 1 : m;
    cfg_stop = LEN_W'(n); cfg_run = LEN_W'(m); cfg_ovh = 16'd8;
    step();
    c0 = cycles;
    auto_ack = 1'b1;
    hot = 1'b1;
    step();
    chk(req == 1'b1, "R2 request one edge after hot", int'(req), 1);
    measure_window(w);
    chk(w == en, "R3 stop window length", w, en);
    measure_gap(g);
    chk(g == em + 1, "R4 run gap length", g, em + 1);
    chk(cycles == c0 + CNT_W'(1), "R9 one cycle counted", int'(cycles), int'(c0 + CNT_W'(1)));
    measure_window(w);
    chk(w == en, "R3 second stop window", w, en);
    go_idle();
  endtask

  task automatic t_cfg_locked();
    int w;
    cfg_stop = 16'd4; cfg_run = 16'd3; cfg_ovh = 16'd8;
    step();
    auto_ack = 1'b1; hot = 1'b1;
    step();
    cfg_stop = 16'd9;
    measure_window(w);
    chk(w == 4, "R10 window unchanged by mid-run config", w, 4);
    while (!req) step();
    measure_window(w);
    chk(w == 4, "R10 later window unchanged", w, 4);
    go_idle();
    auto_ack = 1'b1; hot = 1'b1;
    step();
    measure_window(w);
    chk(w == 9, "R10 new config taken in idle", w, 9);
    go_idle();
  endtask

  task automatic t_run_abort();
    int w, seen;
    cfg_stop = 16'd2; cfg_run = 16'd6; cfg_ovh = 16'd8;
    step();
    auto_ack = 1'b1; hot = 1'b1;
    step();
    measure_window(w);
    step(); step();
    hot = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      step();
      if (req) seen++;
    end
    chk(seen == 0, "R6 no request after hot clears in run", seen, 0);
    chk(err == 1'b0, "R6 no error", int'(err), 0);
    go_idle();
  endtask

  task automatic t_stop_abort();
    int w, seen;
    logic [CNT_W-1:0] c0;
    cfg_stop = 16'd5; cfg_run = 16'd2; cfg_ovh = 16'd8;
    step();
    c0 = cycles;
    auto_ack = 1'b1; hot = 1'b1;
    step();
    step();
    hot = 1'b0;
    w = (req && ack) ? 1 : 0;
    for (int i = 0; i < 100 && req; i++) begin
      step();
      if (req && ack) w++;
    end
    chk(w == 5, "R5 window completes after hot clears", w, 5);
    step(); step();
    chk(cycles == c0 + CNT_W'(1), "R5 cycle counted", int'(cycles), int'(c0 + CNT_W'(1)));
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      step();
      if (req) seen++;
    end
    chk(seen == 0, "R5 no new request", seen, 0);
    go_idle();
  endtask

  task automatic t_req_timeout(input int l);
    int k, le;
    le = (l == 0) ? 1 : l;
    cfg_stop = 16'd2; cfg_run = 16'd2; cfg_ovh = LEN_W'(l);
    step();
    auto_ack = 1'b0; ack = 1'b0; hot = 1'b1;
    k = 0;
    for (int i = 0; i < 100; i++) begin
      step(); k++;
      if (err) break;
    end
    chk(k == le + 1, "R7 timeout sample while waiting for ack", k, le + 1);
    chk(req == 1'b0, "R7 request dropped on timeout", int'(req), 0);
    hot = 1'b0;
    step();
    chk(err == 1'b0, "R7 error is a single pulse", int'(err), 0);
    go_idle();
  endtask

  task automatic t_resume_timeout(input int l);
    int k;
    logic [CNT_W-1:0] c0;
    cfg_stop = 16'd2; cfg_run = 16'd2; cfg_ovh = LEN_W'(l);
    step();
    c0 = cycles;
    auto_ack = 1'b0; ack = 1'b0; hot = 1'b1;
    step();
    ack = 1'b1;
    step();
    hot = 1'b0;
    while (req) step();
    k = 0;
    for (int i = 0; i < 100; i++) begin
      if (err) break;
      step(); k++;
    end
    chk(k == l, "R8 timeout while ack stays high", k, l);
    chk(cycles == c0, "R8 cycle not counted", int'(cycles), int'(c0));
    go_idle();
  endtask

  task automatic t_wrap();
    logic [CNT_W-1:0] c0, prev;
    int incs, bad;
    cfg_stop = 16'd1; cfg_run = 16'd1; cfg_ovh = 16'd8;
    step();
    c0 = cycles; prev = cycles;
    incs = 0; bad = 0;
    auto_ack = 1'b1; hot = 1'b1;
    for (int i = 0; i < 2000 && incs < (1 << CNT_W); i++) begin
      step();
      if (cycles != prev) begin
        if (cycles != prev + CNT_W'(1)) bad++;
        incs++;
        prev = cycles;
      end
    end
    chk(bad == 0, "R9 count steps by one", bad, 0);
    chk(incs == (1 << CNT_W) && cycles == c0, "R9 count wraps", int'(cycles), int'(c0));
    go_idle();
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic(3, 5);
    t_basic(1, 1);
    t_basic(0, 0);
    t_basic(7, 2);
    t_cfg_locked();
    t_run_abort();
    t_stop_abort();
    t_req_timeout(4);
    t_req_timeout(0);
    t_resume_timeout(3);
    t_wrap();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule